// File: doc/BRIEF.md
# Plastic Leaky Integrate-and-Fire Neuron Engine

This block updates a small population of leaky integrate-and-fire neurons that share one arithmetic lane by time multiplexing. Each virtual neuron has a membrane potential, excitatory and inhibitory conductances, a postsynaptic activity trace and an adaptive threshold offset. Each of its synapses has a weight and a presynaptic activity trace. All quantities are 16-bit signed integers, where one unit is 10 µV for potentials. Every exponential decay is a multiply by a Q0.15 factor with round-half-up, and every addition saturates at the 16-bit signed limits.

A time-step tick starts a sweep. The sweep visits the virtual neurons in ascending order, one per clock cycle. It decays the neuron state, integrates the conductance current into the membrane, tests the membrane against the adaptive threshold and applies the postsynaptic plasticity. Presynaptic spike events name a virtual neuron and a synapse. They step a conductance by the synapse weight and apply the presynaptic half of the trace-based STDP rule. Each state update appears on a write-back bus that carries the neuron's new membrane, threshold offset and weights.

A learning-enable input gates the plasticity. While it is low, weights and threshold offsets hold their values.

Top module: `lif_plastic_neuron`

## Requirements
- R1: After reset, every membrane equals V_REST, and every conductance, trace and threshold offset is zero. Every weight equals W_INIT, and wbValid is low until the first update.
- R2: When tick is accepted while no sweep is running, virtual neurons 0 to NUM_VN-1 are updated one per cycle in the following NUM_VN cycles. Each update is reported with wbValid high and wbVn equal to that index. A tick that arrives during a sweep is ignored.
- R3: During its sweep cycle, a neuron's membrane becomes V_REST + decay(V - V_REST, A_M) + ((gEx - gIh) * GAIN >>> 8). The result saturates to 16 bits, and the conductances used are the values held before the sweep cycle decays them.
- R4: When the integrated membrane is greater than or equal to V_TH + theta, wbFire is high and the stored membrane becomes V_REST.
- R5: A presynaptic event on a synapse with index below NUM_EXC adds that synapse's weight to gEx. An event on any other synapse adds the weight to gIh. Each conductance decays by its own factor, A_GEX or A_GIH, once per sweep.
- R6: With learning enabled, a presynaptic event on an excitatory synapse adds D_APRE to that synapse's trace and adds the neuron's postsynaptic trace to the weight. The postsynaptic trace is negative after depression.
- R7: On a postsynaptic spike, the postsynaptic trace gains D_APOST. With learning enabled, every excitatory weight of the neuron gains that synapse's presynaptic trace, taken after the trace has decayed in the same cycle.
- R8: Every weight stays within 0 to W_MAX after every update. wbWeights carries synapse s in bits [16s+15:16s].
- R9: With learning enabled, theta gains D_THETA on each output spike. Theta decays by A_THETA only during the sweep of every UNDERSAMPLE-th accepted tick, and the spike test in that sweep uses the decayed value.
- R10: While learnEn is low, no weight and no theta changes.
- R11: An event that arrives in the sweep cycle of the neuron it names is merged into that sweep, ahead of integration. An event that arrives during a sweep and names another neuron is dropped.
- R12: Conductances and the membrane saturate at 32767 and -32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-step strobe that starts a sweep |
| learnEn | input | 1 | Enables weight and threshold adaptation |
| preValid | input | 1 | Presynaptic event strobe |
| preVn | input | VN_W | Virtual neuron targeted by the event |
| preSyn | input | SYN_W | Synapse index of the event |
| wbValid | output | 1 | A neuron record was written in the previous cycle |
| wbVn | output | VN_W | Index of the written neuron |
| wbFire | output | 1 | The written neuron emitted a spike |
| wbV | output | 16 | New membrane potential |
| wbTheta | output | 16 | New threshold offset |
| wbWeights | output | NUM_SYN*16 | New weights of the written neuron |

## Verification
A presynaptic event and the neuron's own sweep can fall in the same cycle. A postsynaptic spike and a presynaptic weight change can then act on the same synapse. The bench provokes this by raising preValid in the cycle right after an accepted tick, aimed at neuron 0. The combined weight and spike outcome must match an event that was applied before the sweep's decay and integration. A second run aims the event at neuron 1 during neuron 0's sweep cycle, and neuron 1's membrane must show that the event was discarded.

// File: rtl/lif_pkg.sv
package lif_pkg;

  typedef struct packed {
    logic sweep;       // lane is updating the neuron selected by the sequencer
    logic evAccept;    // a presynaptic event is applied to the lane neuron
    logic thetaDecay;  // the current sweep applies the slow threshold decay
  } laneCtl_t;

  function automatic logic signed [15:0] sat16(input logic signed [31:0] x);
    if (x > 32'sd32767) return 16'sh7fff;
    if (x < -32'sd32768) return 16'sh8000;
    return x[15:0];
  endfunction

  // multiply by a Q0.15 factor, round half up
  function automatic logic signed [15:0] decayQ15(input logic signed [15:0] x,
                                                  input logic [15:0] a);
    logic signed [31:0] p;
    logic signed [31:0] r;
    p = 32'(x) * $signed({16'd0, a});
    r = (p + 32'sd16384) >>> 15;
    return r[15:0];
  endfunction

endpackage

// File: rtl/lif_ctrl.sv
module lif_ctrl
  import lif_pkg::*;
#(
  parameter int NUM_VN     = 8,
  parameter int UNDERSAMPLE = 10000,
  localparam int VN_W  = $clog2(NUM_VN),
  localparam int CNT_W = $clog2(UNDERSAMPLE + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            preValid,
  input  logic [VN_W-1:0] preVn,
  output laneCtl_t        ctl,
  output logic [VN_W-1:0] laneVn
);

  localparam logic [VN_W-1:0] LAST_VN = VN_W'(NUM_VN - 1);

  logic             busy;
  logic [VN_W-1:0]  sweepVn;
  logic [CNT_W-1:0] tickCnt;
  logic             thetaDue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sweepVn  <= '0;
      tickCnt  <= '0;
      thetaDue <= 1'b0;
    end else if (!busy && tick) begin
      busy    <= 1'b1;
      sweepVn <= '0;
      if (tickCnt == CNT_W'(UNDERSAMPLE - 1)) begin
        tickCnt  <= '0;
        thetaDue <= 1'b1;
      end else begin
        tickCnt  <= tickCnt + 1'b1;
        thetaDue <= 1'b0;
      end
    end else if (busy) begin
      if (sweepVn == LAST_VN) busy <= 1'b0;
      else                    sweepVn <= sweepVn + 1'b1;
    end
  end

  always_comb begin
    ctl.sweep      = busy;
    ctl.evAccept   = preValid && (!busy || preVn == sweepVn);
    ctl.thetaDecay = thetaDue;
    laneVn         = busy ? sweepVn : preVn;
  end

  // R9: the undersampling counter never leaves its range
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < CNT_W'(UNDERSAMPLE));

endmodule

// File: rtl/lif_datapath.sv
module lif_datapath
  import lif_pkg::*;
#(
  parameter int NUM_VN  = 8,
  parameter int NUM_SYN = 4,
  parameter int NUM_EXC = 3,
  parameter int V_REST  = 0,
  parameter int V_TH    = 2000,
  parameter int W_MAX   = 1000,
  parameter int W_INIT  = 200,
  parameter int D_APRE  = 50,
  parameter int D_APOST = -60,
  parameter int D_THETA = 20,
  parameter int GAIN    = 256,
  parameter int A_M     = 31130,
  parameter int A_GEX   = 26800,
  parameter int A_GIH   = 29650,
  parameter int A_PRE   = 31130,
  parameter int A_POST  = 31130,
  parameter int A_THETA = 32440,
  localparam int VN_W  = $clog2(NUM_VN),
  localparam int SYN_W = $clog2(NUM_SYN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  laneCtl_t                 ctl,
  input  logic [VN_W-1:0]          laneVn,
  input  logic [SYN_W-1:0]         preSyn,
  input  logic                     learnEn,
  output logic                     wbValid,
  output logic [VN_W-1:0]          wbVn,
  output logic                     wbFire,
  output logic signed [15:0]       wbV,
  output logic signed [15:0]       wbTheta,
  output logic [NUM_SYN*16-1:0]    wbWeights
);

  // neuron and synapse records
  logic signed [15:0] vMem  [NUM_VN];
  logic signed [15:0] gEx   [NUM_VN];
  logic signed [15:0] gIh   [NUM_VN];
  logic signed [15:0] aPost [NUM_VN];
  logic signed [15:0] theta [NUM_VN];
  logic signed [15:0] wgt   [NUM_VN][NUM_SYN];
  logic signed [15:0] aPre  [NUM_VN][NUM_SYN];

  logic signed [15:0] vCur, gExCur, gIhCur, aPostCur, thCur, evW;
  logic               evExc, fire, wbSweep;
  logic signed [15:0] gExB, gIhB, vRel, vInt, thD;
  logic signed [31:0] curr;
  logic signed [15:0] vNext, thNext, aPostNext, gExNext, gIhNext;
  logic signed [15:0] wB [NUM_SYN];
  logic signed [15:0] aPreB [NUM_SYN];
  logic signed [15:0] aPreS [NUM_SYN];
  logic signed [15:0] wNext [NUM_SYN];
  logic signed [15:0] aPreNext [NUM_SYN];

  function automatic logic signed [15:0] clampW(input logic signed [31:0] x);
    if (x < 0) return 16'sd0;
    if (x > W_MAX) return 16'(W_MAX);
    return x[15:0];
  endfunction

  always_comb begin
    vCur     = vMem[laneVn];
    gExCur   = gEx[laneVn];
    gIhCur   = gIh[laneVn];
    aPostCur = aPost[laneVn];
    thCur    = theta[laneVn];
    evW      = wgt[laneVn][preSyn];
    evExc    = int'(preSyn) < NUM_EXC;

    // event stage: conductance step and presynaptic half of STDP
    gExB = (ctl.evAccept && evExc)  ? sat16(32'(gExCur) + 32'(evW)) : gExCur;
    gIhB = (ctl.evAccept && !evExc) ? sat16(32'(gIhCur) + 32'(evW)) : gIhCur;
    for (int s = 0; s < NUM_SYN; s++) begin
      if (ctl.evAccept && preSyn == SYN_W'(s) && s < NUM_EXC) begin
        aPreB[s] = sat16(32'(aPre[laneVn][s]) + D_APRE);
        wB[s]    = learnEn ? clampW(32'(wgt[laneVn][s]) + 32'(aPostCur))
                           : wgt[laneVn][s];
      end else begin
        aPreB[s] = aPre[laneVn][s];
        wB[s]    = wgt[laneVn][s];
      end
    end

    // sweep stage: leak, integrate, fire, postsynaptic half of STDP
    vRel = sat16(32'(vCur) - V_REST);
    curr = ((32'(gExB) - 32'(gIhB)) * GAIN) >>> 8;
    vInt = sat16(V_REST + 32'(decayQ15(vRel, 16'(A_M))) + curr);
    thD  = (ctl.sweep && ctl.thetaDecay && learnEn) ? decayQ15(thCur, 16'(A_THETA)) : thCur;
    fire = ctl.sweep && (32'(vInt) >= V_TH + 32'(thD));

    vNext     = ctl.sweep ? (fire ? 16'(V_REST) : vInt) : vCur;
    thNext    = (fire && learnEn) ? sat16(32'(thD) + D_THETA) : thD;
    aPostNext = ctl.sweep ? sat16(32'(decayQ15(aPostCur, 16'(A_POST))) + (fire ? D_APOST : 0))
                          : aPostCur;
    gExNext   = ctl.sweep ? decayQ15(gExB, 16'(A_GEX)) : gExB;
    gIhNext   = ctl.sweep ? decayQ15(gIhB, 16'(A_GIH)) : gIhB;
    for (int s = 0; s < NUM_SYN; s++) begin
      aPreS[s]    = decayQ15(aPreB[s], 16'(A_PRE));
      aPreNext[s] = ctl.sweep ? aPreS[s] : aPreB[s];
      wNext[s]    = (fire && learnEn && s < NUM_EXC) ? clampW(32'(wB[s]) + 32'(aPreS[s])) : wB[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VN; v++) begin
        vMem[v]  <= 16'(V_REST);
        gEx[v]   <= '0;
        gIh[v]   <= '0;
        aPost[v] <= '0;
        theta[v] <= '0;
        for (int s = 0; s < NUM_SYN; s++) begin
          wgt[v][s]  <= 16'(W_INIT);
          aPre[v][s] <= '0;
        end
      end
      wbValid   <= 1'b0;
      wbSweep   <= 1'b0;
      wbVn      <= '0;
      wbFire    <= 1'b0;
      wbV       <= '0;
      wbTheta   <= '0;
      wbWeights <= '0;
    end else begin
      if (ctl.sweep || ctl.evAccept) begin
        vMem[laneVn]  <= vNext;
        gEx[laneVn]   <= gExNext;
        gIh[laneVn]   <= gIhNext;
        aPost[laneVn] <= aPostNext;
        theta[laneVn] <= thNext;
        for (int s = 0; s < NUM_SYN; s++) begin
          wgt[laneVn][s]  <= wNext[s];
          aPre[laneVn][s] <= aPreNext[s];
        end
      end
      wbValid <= ctl.sweep || ctl.evAccept;
      wbSweep <= ctl.sweep;
      wbVn    <= laneVn;
      wbFire  <= fire;
      wbV     <= vNext;
      wbTheta <= thNext;
      for (int s = 0; s < NUM_SYN; s++) wbWeights[s*16 +: 16] <= wNext[s];
    end
  end

  // packed views for the checks below
  logic [NUM_VN*16-1:0]         thetaPack;
  logic [NUM_VN*NUM_SYN*16-1:0] wgtPack;
  always_comb begin
    for (int v = 0; v < NUM_VN; v++) begin
      thetaPack[v*16 +: 16] = theta[v];
      for (int s = 0; s < NUM_SYN; s++) wgtPack[(v*NUM_SYN+s)*16 +: 16] = wgt[v][s];
    end
  end

  // R10: with learning off, no weight and no threshold offset moves
  p_learn_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    !learnEn |=> ($stable(thetaPack) && $stable(wgtPack)));

  // R4: a spike always leaves the membrane at rest
  p_fire_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    wbFire |-> (wbValid && wbV == 16'(V_REST)));

  // R2: sweep write-backs walk the neurons in ascending order
  p_sweep_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbSweep && wbVn != VN_W'(NUM_VN - 1)) |=>
      (wbValid && wbSweep && wbVn == $past(wbVn) + VN_W'(1)));

  for (genvar gv = 0; gv < NUM_VN; gv++) begin : g_chk
    // R5: excitatory conductance is built from non-negative weights only
    p_gex_nonneg_r5: assert property (@(posedge clk) disable iff (!rstN)
      gEx[gv] >= 16'sd0);
    for (genvar gs = 0; gs < NUM_SYN; gs++) begin : g_syn
      // R8: weights stay inside the clamp range
      p_wclamp_r8: assert property (@(posedge clk) disable iff (!rstN)
        (wgt[gv][gs] >= 16'sd0) && (32'(wgt[gv][gs]) <= W_MAX));
    end
  end

endmodule

// File: rtl/lif_plastic_neuron.sv
module lif_plastic_neuron
  import lif_pkg::*;
#(
  parameter int NUM_VN      = 8,
  parameter int NUM_SYN     = 4,
  parameter int NUM_EXC     = 3,
  parameter int UNDERSAMPLE = 10000,
  parameter int V_REST      = 0,
  parameter int V_TH        = 2000,
  parameter int W_MAX       = 1000,
  parameter int W_INIT      = 200,
  parameter int D_APRE      = 50,
  parameter int D_APOST     = -60,
  parameter int D_THETA     = 20,
  parameter int GAIN        = 256,
  parameter int A_M         = 31130,
  parameter int A_GEX       = 26800,
  parameter int A_GIH       = 29650,
  parameter int A_PRE       = 31130,
  parameter int A_POST      = 31130,
  parameter int A_THETA     = 32440,
  localparam int VN_W  = $clog2(NUM_VN),
  localparam int SYN_W = $clog2(NUM_SYN)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  learnEn,
  input  logic                  preValid,
  input  logic [VN_W-1:0]       preVn,
  input  logic [SYN_W-1:0]      preSyn,
  output logic                  wbValid,
  output logic [VN_W-1:0]       wbVn,
  output logic                  wbFire,
  output logic signed [15:0]    wbV,
  output logic signed [15:0]    wbTheta,
  output logic [NUM_SYN*16-1:0] wbWeights
);

  laneCtl_t        ctl;
  logic [VN_W-1:0] laneVn;

  lif_ctrl #(.NUM_VN(NUM_VN), .UNDERSAMPLE(UNDERSAMPLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .preValid(preValid), .preVn(preVn),
    .ctl(ctl), .laneVn(laneVn)
  );

  lif_datapath #(
    .NUM_VN(NUM_VN), .NUM_SYN(NUM_SYN), .NUM_EXC(NUM_EXC), .V_REST(V_REST),
    .V_TH(V_TH), .W_MAX(W_MAX), .W_INIT(W_INIT), .D_APRE(D_APRE),
    .D_APOST(D_APOST), .D_THETA(D_THETA), .GAIN(GAIN), .A_M(A_M),
    .A_GEX(A_GEX), .A_GIH(A_GIH), .A_PRE(A_PRE), .A_POST(A_POST),
    .A_THETA(A_THETA)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .laneVn(laneVn), .preSyn(preSyn),
    .learnEn(learnEn), .wbValid(wbValid), .wbVn(wbVn), .wbFire(wbFire),
    .wbV(wbV), .wbTheta(wbTheta), .wbWeights(wbWeights)
  );

endmodule

// File: tb/test_lif_plastic_neuron.sv
module test_lif_plastic_neuron;

  localparam int NV = 2;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic learnEn = 1'b1;
  logic preValid = 1'b0;
  logic [0:0] preVn = '0;
  logic [0:0] preSyn = '0;
  logic wbValid, wbFire;
  logic [0:0] wbVn;
  logic signed [15:0] wbV, wbTheta;
  logic [NS*16-1:0] wbWeights;

  always #10 clk = ~clk;

  lif_plastic_neuron #(
    .NUM_VN(NV), .NUM_SYN(NS), .NUM_EXC(1), .UNDERSAMPLE(3), .V_REST(0),
    .V_TH(100), .W_MAX(200), .W_INIT(50), .D_APRE(20), .D_APOST(-100),
    .D_THETA(40), .GAIN(256), .A_M(16384), .A_GEX(0), .A_GIH(0),
    .A_PRE(16384), .A_POST(16384), .A_THETA(16384)
  ) i_lif_plastic_neuron (
    .clk(clk), .rstN(rstN), .tick(tick), .learnEn(learnEn), .preValid(preValid),
    .preVn(preVn), .preSyn(preSyn), .wbValid(wbValid), .wbVn(wbVn),
    .wbFire(wbFire), .wbV(wbV), .wbTheta(wbTheta), .wbWeights(wbWeights)
  );

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  int gotV [NV], gotTh [NV], gotW0 [NV], gotW1 [NV], gotFire [NV];

  task automatic check(input string tag, input int got, input int exp);
    testCnt++;
    if (got != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic capture(input int k);
    gotV[k]    = int'(wbV);
    gotTh[k]   = int'(wbTheta);
    gotW0[k]   = int'($signed(wbWeights[15:0]));
    gotW1[k]   = int'($signed(wbWeights[31:16]));
    gotFire[k] = int'(wbFire);
  endtask

  task automatic doEvents(input int vn, input int syn, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      preValid = 1'b1; preVn = 1'(vn); preSyn = 1'(syn);
      @(posedge clk);
    end
    @(negedge clk);
    preValid = 1'b0;
    capture(vn);
  endtask

  task automatic doTick(input bit merge, input int mVn, input int mSyn);
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
    if (merge) begin preValid = 1'b1; preVn = 1'(mVn); preSyn = 1'(mSyn); end
    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      @(negedge clk);
      preValid = 1'b0;
      check($sformatf("R2 sweep valid vn%0d", k), int'(wbValid), 1);
      check($sformatf("R2 sweep order vn%0d", k), int'(wbVn), k);
      capture(k);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; preValid = 1'b0; tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  typedef struct packed {
    logic               isTick;
    logic               vn;
    logic               syn;
    logic               learn;
    logic [15:0]        reps;
    logic signed [15:0] expV;
    logic signed [15:0] expTh;
    logic signed [15:0] expW0;
    logic               expFire;
    logic [3:0]         req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'd1,   16'sd0,      16'sd0,  16'sd50,  1'b0, 4'd1},  // R1 initial weight
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'd0,   16'sd50,     16'sd0,  16'sd50,  1'b0, 4'd3},  // R3 integrate
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'd2,   16'sd50,     16'sd0,  16'sd50,  1'b0, 4'd5},  // R5 steps
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'd0,   16'sd0,      16'sd40, 16'sd75,  1'b1, 4'd7},  // R7 LTP, R4, R9
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'd1,   16'sd0,      16'sd40, 16'sd0,   1'b0, 4'd6},  // R6 LTD to floor
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'd0,   16'sd75,     16'sd20, 16'sd0,   1'b0, 4'd9},  // R9 slow decay
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'd1,   16'sd75,     16'sd20, 16'sd0,   1'b0, 4'd5},  // R5 inhibitory
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'd0,  -16'sd12,     16'sd20, 16'sd0,   1'b0, 4'd3},  // R3 leak minus gIh
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'd20,  16'sd0,      16'sd0,  16'sd50,  1'b0, 4'd6},  // R6 trace build
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'd0,   16'sd0,      16'sd40, 16'sd200, 1'b1, 4'd8},  // R8 ceiling
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'd1,   16'sd0,      16'sd40, 16'sd200, 1'b0, 4'd10}, // R10 frozen weight
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd0,   16'sd0,      16'sd40, 16'sd200, 1'b1, 4'd10}, // R10 frozen theta
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'd700, 16'sd0,      16'sd40, 16'sd200, 1'b0, 4'd12}, // R12 gIh saturates
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd0,  -16'sd32767,  16'sd40, 16'sd200, 1'b0, 4'd12}, // R12
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'd700, -16'sd32767, 16'sd40, 16'sd200, 1'b0, 4'd12}, // R12
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd0,  -16'sd32768,  16'sd40, 16'sd200, 1'b0, 4'd12}  // R12 membrane floor
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 wbValid low in reset", int'(wbValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 wbValid low after reset", int'(wbValid), 0);

    for (int r = 0; r < NVEC; r++) begin
      int vn;
      vn = int'(VEC[r].vn);
      learnEn = VEC[r].learn;
      if (VEC[r].isTick) doTick(1'b0, 0, 0);
      else               doEvents(vn, int'(VEC[r].syn), int'(VEC[r].reps));
      check($sformatf("R%0d row%0d V", VEC[r].req, r), gotV[vn], int'(VEC[r].expV));
      check($sformatf("R%0d row%0d theta", VEC[r].req, r), gotTh[vn], int'(VEC[r].expTh));
      check($sformatf("R%0d row%0d w0", VEC[r].req, r), gotW0[vn], int'(VEC[r].expW0));
      check($sformatf("R%0d row%0d fire", VEC[r].req, r), gotFire[vn], int'(VEC[r].expFire));
      if (r == 0) check("R1 initial w1", gotW1[0], 50);
      if (r == 6) check("R5 inhibitory weight untouched", gotW1[0], 50);
    end

    // R11: event for the swept neuron merges with its sweep
    doReset();
    check("R1 wbValid low after second reset", int'(wbValid), 0);
    learnEn = 1'b1;
    doEvents(0, 0, 2);
    doTick(1'b1, 0, 0);
    check("R11 merged fire", gotFire[0], 1);
    check("R11 merged weight", gotW0[0], 80);
    check("R11 merged V", gotV[0], 0);
    check("R11 merged theta", gotTh[0], 40);
    // R11: event for another neuron during a sweep is dropped
    doTick(1'b1, 1, 0);
    check("R11 dropped event V vn1", gotV[1], 0);
    check("R11 dropped event w0 vn1", gotW0[1], 50);
    check("R3 decayed conductance vn0", gotV[0], 0);

    // R2: tick during a sweep is ignored
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    repeat (NV) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    check("R2 one sweep per accepted tick", int'(wbValid), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule